// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of procedure returns in a RISC-V front end. Each cycle it takes one 32-bit instruction word with its address and, when the word is a JAL or a JALR, classifies it by whether its destination and source registers are link registers. From that class it pushes the return address, pops a saved address, pops and pushes together, or does nothing. When it pops a saved address, it drives that address as the predicted return target and raises a valid flag.

The stack is circular. A push onto a full stack overwrites the oldest entry. A pop from an empty stack gives no prediction and leaves the stack empty. The block also rebuilds the sign-extended JAL immediate from the instruction word, so that the fetch stage can check the direct target. A synchronous flush empties the stack, for example after a pipeline redirect.

Top module: `rasPredictor`

## Requirements
- R1: Only x1 and x5 count as link registers. An instruction whose destination and source are any other registers (for example x0, x2 or x6) does not change the stack.
- R2: A JALR with a non-link destination and a non-link source leaves the stack unchanged and gives no prediction.
- R3: A JALR with a non-link destination and a link source pops the stack. In the same cycle `predValid` is high and `predTarget` is the top entry.
- R4: A JALR with a link destination and a non-link source pushes `instPc + 4` and gives no prediction.
- R5: A JALR whose destination and source are two different link registers predicts the current top entry and, in the same cycle, replaces that entry with `instPc + 4`, so the depth is unchanged. On an empty stack it gives no prediction and pushes.
- R6: A JALR whose destination and source are the same link register only pushes `instPc + 4` and gives no prediction.
- R7: A JAL (opcode bits 6:0 = 1101111) pushes `instPc + 4` when its destination in bits 11:7 is a link register. Otherwise it does not change the stack. A JAL never predicts.
- R8: `jalOffset` is the JAL immediate, sign-extended from bit 20. Its bit 20 comes from word bit 31, bits 10:1 from bits 30:21, bit 11 from bit 20, bits 19:12 from bits 19:12, and bit 0 is zero.
- R9: A JALR is recognised only with opcode 1100111 and funct3 (bits 14:12) equal to 000, with its source in bits 19:15. Every other word, and any word presented while `instValid` is low, causes no stack action.
- R10: The stack holds 8 entries. After 9 pushes, 8 pops return the last 8 pushed addresses, newest first, and a 9th pop gives no prediction.
- R11: A pop from an empty stack drives `predValid` low and `predTarget` to zero, and the stack stays empty.
- R12: When `flush` is high at a clock edge, the stack is empty after that edge, even if the instruction in the same cycle would push.
- R13: After reset the stack is empty, so the first pop gives no prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Synchronous stack clear |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Instruction word |
| instPc | input | XLEN | Address of the instruction |
| predValid | output | 1 | Predicted return target is valid |
| predTarget | output | XLEN | Predicted return target (zero when not valid) |
| jalOffset | output | XLEN | Sign-extended JAL immediate decoded from `instWord` |

## Verification
`predValid`, `predTarget` and `jalOffset` are combinational in the presented instruction and the current stack, so they are due in the same cycle as the stimulus. The bench samples them one nanosecond after it drives the inputs, before the next rising edge. A push, pop or flush takes effect at the next rising edge, so the bench observes its effect through the prediction of a later pop instruction, never through the same cycle. Every destination and source pairing over a register set of link and non-link registers is swept against a bench stack model, and the expected JAL immediates are computed arithmetically.

// File: rtl/rasPkg.sv
package rasPkg;

  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [6:0] OP_JALR = 7'b1100111;
  localparam logic [2:0] F3_JALR = 3'b000;

  // Stack strobes issued by control to the datapath
  typedef struct packed {
    logic push;
    logic pop;
  } rasStrobe_t;

  function automatic logic isLinkReg(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

endpackage

// File: rtl/rasControl.sv
module rasControl
  import rasPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [31:0]      instWord,
  output rasStrobe_t       strobe
);

  logic [6:0] opcode;
  logic [4:0] rdIdx;
  logic [4:0] rs1Idx;
  logic [2:0] funct3;
  logic       isJal;
  logic       isJalr;
  logic       rdLink;
  logic       rsLink;

  assign opcode = instWord[6:0];
  assign rdIdx  = instWord[11:7];
  assign funct3 = instWord[14:12];
  assign rs1Idx = instWord[19:15];

  assign isJal  = instValid && (opcode == OP_JAL);
  assign isJalr = instValid && (opcode == OP_JALR) && (funct3 == F3_JALR);
  assign rdLink = isLinkReg(rdIdx);
  assign rsLink = isLinkReg(rs1Idx);

  always_comb begin
    strobe = '0;
    if (isJal) begin
      strobe.push = rdLink;
    end else if (isJalr) begin
      unique case ({rdLink, rsLink})
        2'b00: strobe = '0;
        2'b01: strobe.pop = 1'b1;
        2'b10: strobe.push = 1'b1;
        default: begin
          strobe.push = 1'b1;
          strobe.pop  = (rdIdx != rs1Idx);
        end
      endcase
    end
  end

  // A JAL may push but never pops (R7)
  assert_jal_never_pops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[6:0] == OP_JAL) |-> !strobe.pop);

  // Non-jump words and idle slots never touch the stack (R9)
  assert_other_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!instValid || (instWord[6:0] != OP_JAL && instWord[6:0] != OP_JALR))
      |-> (!strobe.push && !strobe.pop));

  // Same link register on both sides never pops (R6)
  assert_same_link_push_R6: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[6:0] == OP_JALR && instWord[14:12] == F3_JALR &&
     instWord[11:7] == instWord[19:15] && isLinkReg(instWord[11:7]))
      |-> (strobe.push && !strobe.pop));

endmodule

// File: rtl/rasDatapath.sv
module rasDatapath
  import rasPkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  rasStrobe_t       strobe,
  input  logic [31:0]      instWord,
  input  logic [XLEN-1:0]  instPc,
  output logic             predValid,
  output logic [XLEN-1:0]  predTarget,
  output logic [XLEN-1:0]  jalOffset
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [XLEN-1:0] entryQ [DEPTH];
  logic [PW-1:0]   topQ, topD;
  logic [CW-1:0]   countQ, countD;
  logic [PW-1:0]   nextPtr, prevPtr, wrIdx;
  logic            wrEn;
  logic            hasData;
  logic [XLEN-1:0] retAddr;

  assign hasData = (countQ != '0);
  assign retAddr = instPc + XLEN'(4);
  assign nextPtr = (topQ == LAST_IDX) ? '0 : topQ + PW'(1);
  assign prevPtr = (topQ == '0) ? LAST_IDX : topQ - PW'(1);

  // Next-state for pointer, depth and write port
  always_comb begin
    wrEn   = 1'b0;
    wrIdx  = topQ;
    topD   = topQ;
    countD = countQ;
    if (flush) begin
      countD = '0;
    end else if (strobe.push && strobe.pop && hasData) begin
      wrEn  = 1'b1;
      wrIdx = topQ;
    end else if (strobe.push) begin
      wrEn   = 1'b1;
      wrIdx  = nextPtr;
      topD   = nextPtr;
      countD = (countQ == FULL_CNT) ? countQ : countQ + CW'(1);
    end else if (strobe.pop && hasData) begin
      topD   = prevPtr;
      countD = countQ - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topQ   <= '0;
      countQ <= '0;
    end else begin
      topQ   <= topD;
      countQ <= countD;
    end
  end

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          entryQ[gi] <= '0;
        end else if (wrEn && !flush && wrIdx == PW'(gi)) begin
          entryQ[gi] <= retAddr;
        end
      end
    end
  endgenerate

  assign predValid  = strobe.pop && hasData;
  assign predTarget = predValid ? entryQ[topQ] : '0;

  // JAL immediate, sign-extended from bit 20
  assign jalOffset = {{(XLEN-20){instWord[31]}}, instWord[19:12], instWord[20],
                      instWord[30:21], 1'b0};

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= FULL_CNT);

  assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (countQ == '0));

  assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.push && !flush && countQ != '0)
      |=> (countQ == $past(countQ) - CW'(1)));

  assert_push_grows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop && !flush && countQ < FULL_CNT)
      |=> (countQ == $past(countQ) + CW'(1)));

  assert_swap_depth_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pop && !flush && countQ != '0)
      |=> (countQ == $past(countQ)));

  assert_empty_no_pred_R11: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '0) |-> (!predValid && predTarget == '0));

endmodule

// File: rtl/rasPredictor.sv
module rasPredictor
  import rasPkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  input  logic [XLEN-1:0] instPc,
  output logic            predValid,
  output logic [XLEN-1:0] predTarget,
  output logic [XLEN-1:0] jalOffset
);

  rasStrobe_t strobe;

  rasControl i_control (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instWord  (instWord),
    .strobe    (strobe)
  );

  rasDatapath #(
    .XLEN  (XLEN),
    .DEPTH (DEPTH)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .strobe     (strobe),
    .instWord   (instWord),
    .instPc     (instPc),
    .predValid  (predValid),
    .predTarget (predTarget),
    .jalOffset  (jalOffset)
  );

endmodule

// File: tb/test_rasPredictor.sv
`timescale 1ns/1ps
module test_rasPredictor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [31:0] instPc = '0;
  logic        predValid;
  logic [31:0] predTarget;
  logic [31:0] jalOffset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench stack model
  logic [31:0] mStack [8];
  int mTop = 0;
  int mCount = 0;
  logic        lastValid;
  logic [31:0] lastTarget;

  always #2.5 clk = ~clk;

  rasPredictor i_rasPredictor (
    .clk(clk), .rstN(rstN), .flush(flush), .instValid(instValid),
    .instWord(instWord), .instPc(instPc), .predValid(predValid),
    .predTarget(predTarget), .jalOffset(jalOffset)
  );

  function automatic logic [31:0] encJal(input logic [4:0] rd, input logic [20:0] imm);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] encJalr(input logic [4:0] rd, input logic [4:0] rs1,
                                          input logic [2:0] f3);
    return {12'h000, rs1, f3, rd, 7'b1100111};
  endfunction

  function automatic bit isLink(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present one instruction, check same-cycle outputs, then clock it in.
  task automatic step(input logic [31:0] w, input logic [31:0] pc, input logic v,
                      input logic fl, input string tag);
    bit doPush, doPop, expValid;
    logic [31:0] expTarget;
    logic [4:0] rd, rs;
    instWord = w; instPc = pc; instValid = v; flush = fl;
    rd = w[11:7]; rs = w[19:15];
    doPush = 0; doPop = 0;
    if (v && w[6:0] == 7'b1101111) doPush = isLink(rd);
    else if (v && w[6:0] == 7'b1100111 && w[14:12] == 3'b000) begin
      if (isLink(rd) && isLink(rs)) begin doPush = 1; doPop = (rd != rs); end
      else begin doPush = isLink(rd); doPop = isLink(rs); end
    end
    expValid  = doPop && (mCount > 0);
    expTarget = expValid ? mStack[mTop] : 32'h0;
    #1;
    check(predValid == expValid, {tag, " predValid"}, 32'(predValid), 32'(expValid));
    check(predTarget == expTarget, {tag, " predTarget"}, predTarget, expTarget);
    if (w[6:0] == 7'b1101111) begin
      logic [31:0] expOff;
      expOff = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
      check(jalOffset == expOff, {tag, " R8 jalOffset"}, jalOffset, expOff);
    end
    lastValid = predValid; lastTarget = predTarget;
    @(posedge clk);
    if (fl) mCount = 0;
    else if (doPush && doPop && mCount > 0) mStack[mTop] = pc + 4;
    else if (doPush) begin
      mTop = (mTop + 1) % 8; mStack[mTop] = pc + 4;
      if (mCount < 8) mCount++;
    end else if (doPop && mCount > 0) begin
      mTop = (mTop + 7) % 8; mCount--;
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int regs[5] = '{0, 1, 2, 5, 6};
    logic [20:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R13 reset: empty stack, pop gives nothing; R11 underflow
    step(encJalr(5'd0, 5'd1, 3'd0), 32'h0000_0040, 1, 0, "R13 reset pop");
    check(lastValid == 0, "R11 empty pop", 32'(lastValid), 0);
    step(encJalr(5'd0, 5'd5, 3'd0), 32'h0000_0044, 1, 0, "R11 second empty pop");

    // R7 JAL push, R3 pop predicts pc+4
    step(encJal(5'd1, 21'h00010), 32'h0000_0100, 1, 0, "R7 jal x1");
    step(encJalr(5'd0, 5'd1, 3'd0), 32'h0000_0200, 1, 0, "R3 ret");
    check(lastValid && lastTarget == 32'h104, "R3 literal", lastTarget, 32'h104);

    // R1 / R7 non-link JAL does not push
    step(encJal(5'd2, 21'h00020), 32'h0000_0300, 1, 0, "R1 jal x2");
    step(encJalr(5'd0, 5'd1, 3'd0), 32'h0000_0304, 1, 0, "R1 pop after x2");
    check(lastValid == 0, "R1 literal", 32'(lastValid), 0);

    // Sweep every rd/rs1 pairing: R2 R4 R5 R6
    foreach (regs[a]) begin
      foreach (regs[b]) begin
        step(encJal(5'd1, 21'h0), 32'h0000_1000, 1, 1, "R12 flush prep");
        step(encJal(5'd1, 21'h8), 32'h0000_2000, 1, 0, "R4 prep push a");
        step(encJal(5'd5, 21'h8), 32'h0000_3000, 1, 0, "R4 prep push b");
        step(encJalr(5'(regs[a]), 5'(regs[b]), 3'd0), 32'h0000_4000 + 32'(a * 64 + b * 4),
             1, 0, "R2 R4 R5 R6 sweep jalr");
        for (int k = 0; k < 4; k++)
          step(encJalr(5'd0, 5'd1, 3'd0), 32'h0000_5000, 1, 0, "R3 R5 sweep drain");
      end
    end

    // R5 literal: swap predicts old top, depth unchanged
    step(encJal(5'd1, 21'h0), 32'h0000_0000, 1, 1, "R12 flush");
    step(encJal(5'd1, 21'h8), 32'h0000_0A00, 1, 0, "R5 push");
    step(encJalr(5'd1, 5'd5, 3'd0), 32'h0000_0B00, 1, 0, "R5 swap");
    check(lastValid && lastTarget == 32'hA04, "R5 literal pred", lastTarget, 32'hA04);
    step(encJalr(5'd0, 5'd1, 3'd0), 32'h0000_0C00, 1, 0, "R5 after swap");
    check(lastValid && lastTarget == 32'hB04, "R5 literal new top", lastTarget, 32'hB04);
    step(encJalr(5'd0, 5'd1, 3'd0), 32'h0000_0C04, 1, 0, "R5 depth one");
    check(lastValid == 0, "R5 depth unchanged", 32'(lastValid), 0);

    // R9: bad funct3, other opcode, instValid low
    step(encJal(5'd1, 21'h8), 32'h0000_0D00, 1, 0, "R9 push");
    step(encJalr(5'd1, 5'd0, 3'd1), 32'h0000_0E00, 1, 0, "R9 funct3");
    step(32'h0000_00B3, 32'h0000_0E04, 1, 0, "R9 other op");
    step(encJal(5'd1, 21'h8), 32'h0000_0E08, 0, 0, "R9 invalid slot");
    step(encJalr(5'd0, 5'd1, 3'd0), 32'h0000_0E0C, 1, 0, "R9 pop");
    check(lastValid && lastTarget == 32'hD04, "R9 literal", lastTarget, 32'hD04);

    // R10 overflow
    for (int k = 0; k < 9; k++)
      step(encJal(5'd5, 21'h4), 32'h0001_0000 + 32'(k * 16), 1, 0, "R10 push");
    for (int k = 0; k < 9; k++) begin
      step(encJalr(5'd0, 5'd5, 3'd0), 32'h0002_0000, 1, 0, "R10 pop");
      if (k < 8)
        check(lastValid && lastTarget == 32'h0001_0004 + 32'((8 - k) * 16),
              "R10 literal", lastTarget, 32'h0001_0004 + 32'((8 - k) * 16));
      else
        check(lastValid == 0, "R10 ninth pop", 32'(lastValid), 0);
    end

    // R12 flush wins over a push in the same cycle
    step(encJal(5'd1, 21'h8), 32'h0000_0F00, 1, 0, "R12 push");
    step(encJal(5'd1, 21'h8), 32'h0000_0F10, 1, 1, "R12 flush with push");
    step(encJalr(5'd0, 5'd1, 3'd0), 32'h0000_0F20, 1, 0, "R12 pop after flush");
    check(lastValid == 0, "R12 literal", 32'(lastValid), 0);

    // R8 offset sweep (rd=x0, no push)
    lfsr = 21'h1ACE5;
    for (int k = 0; k < 64; k++) begin
      lfsr = {lfsr[19:0], lfsr[20] ^ lfsr[18]};
      step(encJal(5'd0, {lfsr[20:1], 1'b0}), 32'h0003_0000, 1, 0, "R8 sweep");
    end
    step(encJal(5'd0, 21'h100000), 32'h0, 1, 0, "R8 most negative");
    step(encJal(5'd0, 21'h0FFFFE), 32'h0, 1, 0, "R8 most positive");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule